// File: doc/BRIEF.md
# Reuse-Aware Circuit Set Replacement

This block keeps track of the outgoing circuits that one source node holds open at the same time. It has a fixed number of slots. Each slot stores a destination tag, a weighted reuse score, the request index of its last use, and a predicted reuse distance with a confidence bit. For every request the block reports whether the destination already owns a slot (a hit) or not (a miss). On a miss it names the slot that receives the new circuit. Empty slots are used first. When every slot is full, a victim is chosen by one of two policies, and the mode input selects the policy for each request.

The score policy rewards reuses that come close together and evicts the slot with the lowest score. The next-use policy estimates how many requests remain until each circuit is needed again. It builds that estimate from a predicted distance that an external predictor writes into the slot, and it falls back to the time since the slot's last use whenever the estimate is unusable. The slot whose next use lies farthest away is evicted. The request index counts the requests seen since reset. The response is registered and appears one cycle after the request.

Top module: `reuse_circuit_set`

## Requirements
- R1: A request sampled with `req_valid_i` high produces `resp_valid_o` high exactly one cycle later, and a cycle without a request produces no response. When the destination matches a valid slot's tag, the response has `hit_o`=1 and `slot_o` set to that slot.
- R2: On a miss while any slot is empty, the lowest-numbered empty slot is filled: `fill_o`=1, `evict_o`=0, `slot_o` is that slot.
- R3: A filled slot starts with score 0 and last-use index equal to the current request index, and its prediction is set to distance 0 and not confident.
- R4: On a hit, the slot's score grows by 2^MAX_BIN − d. Here d is the number of requests strictly between the previous use and this one, and d is taken as 0 when the index has saturated and no requests lie between. The increment is 0 when d ≥ 2^MAX_BIN. The last-use index then becomes the current index.
- R5: With `mode_i`=0 and all slots full, a miss evicts the slot with the lowest score. On a tie the lowest slot number wins.
- R6: With `mode_i`=1, a slot whose prediction is confident and whose last-use index plus predicted distance is at least the current index has the key last + predicted − current.
- R7: With `mode_i`=1, any other slot uses the decay key current − last.
- R8: With `mode_i`=1 and all slots full, a miss evicts the slot with the largest key. On a tie the lowest slot number wins.
- R9: Scores saturate at their all-ones value and the request index saturates at its all-ones value. Neither wraps.
- R10: A predictor write (`pred_we_i`) sets the predicted distance and the confidence bit of `pred_slot_i` and produces no response. It is discarded when the same slot is filled in that cycle. It takes effect alongside a hit on that slot.
- R11: While reset is asserted and after it is released, there is no response, and all slots are empty.
- R12: Every miss has `fill_o`=1. `evict_o`=1 occurs only on a miss that finds no empty slot, and `hit_o` and `fill_o` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Circuit request strobe |
| req_dest_i | input | DEST_W | Requested destination |
| mode_i | input | 1 | Replacement policy: 0 score, 1 next-use |
| pred_we_i | input | 1 | Predictor result write strobe |
| pred_slot_i | input | SLOT_W | Slot that the predictor result targets |
| pred_dist_i | input | IDX_W | Predicted reuse distance |
| pred_conf_i | input | 1 | Prediction is confident |
| resp_valid_o | output | 1 | Response valid, one cycle after the request |
| hit_o | output | 1 | Destination already held a circuit |
| fill_o | output | 1 | New circuit is written into `slot_o` |
| evict_o | output | 1 | The filled slot held a circuit that is now torn down |
| slot_o | output | SLOT_W | Slot that was hit or filled |

## Verification
Two functions can fall in the same cycle: a request, which may hit or fill a slot, and a predictor write aimed at that same slot. Directed cases drive a predictor write with a large confident distance in the very cycle that fills its slot. The next next-use miss must then treat the slot as decaying. Other cases drive the predictor write together with a hit, and there the next eviction must honour the new prediction. Random stimulus mixes predictor writes with requests at a high rate, and every response is compared against a reference model of the slots.

// File: rtl/reuse_cs_pkg.sv
package reuse_cs_pkg;
  typedef enum logic {
    MODE_SCORE    = 1'b0,
    MODE_NEXT_USE = 1'b1
  } repl_mode_e;
endpackage

// File: rtl/rcs_slot.sv
module rcs_slot #(
  parameter int DEST_W  = 8,
  parameter int IDX_W   = 16,
  parameter int SCORE_W = 16,
  parameter int MAX_BIN = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [IDX_W-1:0]   cur_idx_i,
  input  logic [DEST_W-1:0]  req_dest_i,
  input  logic               hit_i,
  input  logic               fill_i,
  input  logic               pred_we_i,
  input  logic [IDX_W-1:0]   pred_dist_i,
  input  logic               pred_conf_i,
  output logic               valid_o,
  output logic               match_o,
  output logic [SCORE_W-1:0] score_o,
  output logic [IDX_W:0]     next_use_key_o
);
  localparam int WGT_W = MAX_BIN + 1;
  localparam logic [IDX_W:0] SPAN = (IDX_W+1)'(1) << MAX_BIN;

  logic               valid_q;
  logic [DEST_W-1:0]  tag_q;
  logic [SCORE_W-1:0] score_q;
  logic [IDX_W-1:0]   last_q;
  logic [IDX_W-1:0]   pred_q;
  logic               conf_q;

  logic [IDX_W-1:0]   gap;
  logic [IDX_W:0]     wgt_full;
  logic [WGT_W-1:0]   wgt;
  logic [SCORE_W:0]   score_sum;
  logic [SCORE_W-1:0] score_next;
  logic [IDX_W:0]     eta_sum;
  logic [IDX_W:0]     cur_ext;
  logic [IDX_W:0]     last_ext;

  // requests strictly between two uses
  assign gap        = (cur_idx_i > last_q) ? (cur_idx_i - last_q - IDX_W'(1)) : '0;
  assign wgt_full   = ({1'b0, gap} >= SPAN) ? '0 : (SPAN - {1'b0, gap});
  assign wgt        = WGT_W'(wgt_full);
  assign score_sum  = {1'b0, score_q} + (SCORE_W+1)'(wgt);
  assign score_next = score_sum[SCORE_W] ? '1 : score_sum[SCORE_W-1:0];

  assign cur_ext  = {1'b0, cur_idx_i};
  assign last_ext = {1'b0, last_q};
  assign eta_sum  = last_ext + {1'b0, pred_q};

  always_comb begin
    if (conf_q && (eta_sum >= cur_ext)) next_use_key_o = eta_sum - cur_ext;
    else                                next_use_key_o = cur_ext - last_ext;
  end

  assign valid_o = valid_q;
  assign match_o = valid_q && (tag_q == req_dest_i);
  assign score_o = score_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      score_q <= '0;
      last_q  <= '0;
      pred_q  <= '0;
      conf_q  <= 1'b0;
    end else if (fill_i) begin
      valid_q <= 1'b1;
      tag_q   <= req_dest_i;
      score_q <= '0;
      last_q  <= cur_idx_i;
      pred_q  <= '0;
      conf_q  <= 1'b0;
    end else begin
      if (hit_i) begin
        score_q <= score_next;
        last_q  <= cur_idx_i;
      end
      if (pred_we_i) begin
        pred_q <= pred_dist_i;
        conf_q <= pred_conf_i;
      end
    end
  end
endmodule

// File: rtl/rcs_pick.sv
module rcs_pick #(
  parameter int N        = 8,
  parameter int KEY_W    = 16,
  parameter int SLOT_W   = 3,
  parameter bit FIND_MAX = 1'b0
) (
  input  logic [N-1:0][KEY_W-1:0] keys_i,
  output logic [SLOT_W-1:0]       idx_o
);
  logic [KEY_W-1:0] best_key;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best_key = keys_i[0];
    idx_o    = '0;
    for (int i = 1; i < N; i++) begin
      if (FIND_MAX ? (keys_i[i] > best_key) : (keys_i[i] < best_key)) begin
        best_key = keys_i[i];
        idx_o    = SLOT_W'(i);
      end
    end
  end
endmodule

// File: rtl/reuse_circuit_set.sv
module reuse_circuit_set
  import reuse_cs_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int DEST_W    = 8,
  parameter int IDX_W     = 16,
  parameter int SCORE_W   = 16,
  parameter int MAX_BIN   = 6,
  parameter int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [DEST_W-1:0] req_dest_i,
  input  logic              mode_i,
  input  logic              pred_we_i,
  input  logic [SLOT_W-1:0] pred_slot_i,
  input  logic [IDX_W-1:0]  pred_dist_i,
  input  logic              pred_conf_i,
  output logic              resp_valid_o,
  output logic              hit_o,
  output logic              fill_o,
  output logic              evict_o,
  output logic [SLOT_W-1:0] slot_o
);
  localparam int KEY_W = IDX_W + 1;

  logic [IDX_W-1:0]                    cur_idx_q;
  logic [NUM_SLOTS-1:0]                slot_valid;
  logic [NUM_SLOTS-1:0]                slot_match;
  logic [NUM_SLOTS-1:0][SCORE_W-1:0]   score_keys;
  logic [NUM_SLOTS-1:0][KEY_W-1:0]     next_use_keys;
  logic [NUM_SLOTS-1:0]                hit_vec;
  logic [NUM_SLOTS-1:0]                fill_vec;
  logic [NUM_SLOTS-1:0]                pred_vec;

  logic              any_hit;
  logic [SLOT_W-1:0] hit_idx;
  logic [SLOT_W-1:0] empty_idx;
  logic              all_full;
  logic [SLOT_W-1:0] min_score_idx;
  logic [SLOT_W-1:0] max_key_idx;
  logic [SLOT_W-1:0] victim_idx;
  logic [SLOT_W-1:0] fill_idx;
  repl_mode_e        mode;

  assign mode = repl_mode_e'(mode_i);

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    rcs_slot #(
      .DEST_W (DEST_W),
      .IDX_W  (IDX_W),
      .SCORE_W(SCORE_W),
      .MAX_BIN(MAX_BIN)
    ) u_slot (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .cur_idx_i     (cur_idx_q),
      .req_dest_i    (req_dest_i),
      .hit_i         (hit_vec[g]),
      .fill_i        (fill_vec[g]),
      .pred_we_i     (pred_vec[g]),
      .pred_dist_i   (pred_dist_i),
      .pred_conf_i   (pred_conf_i),
      .valid_o       (slot_valid[g]),
      .match_o       (slot_match[g]),
      .score_o       (score_keys[g]),
      .next_use_key_o(next_use_keys[g])
    );
  end

  rcs_pick #(
    .N       (NUM_SLOTS),
    .KEY_W   (SCORE_W),
    .SLOT_W  (SLOT_W),
    .FIND_MAX(1'b0)
  ) u_pick_score (
    .keys_i(score_keys),
    .idx_o (min_score_idx)
  );

  rcs_pick #(
    .N       (NUM_SLOTS),
    .KEY_W   (KEY_W),
    .SLOT_W  (SLOT_W),
    .FIND_MAX(1'b1)
  ) u_pick_next_use (
    .keys_i(next_use_keys),
    .idx_o (max_key_idx)
  );

  // tags are unique, so at most one match
  always_comb begin
    any_hit = |slot_match;
    hit_idx = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (slot_match[i]) hit_idx = SLOT_W'(i);
    end
  end

  always_comb begin
    all_full  = &slot_valid;
    empty_idx = '0;
    for (int i = NUM_SLOTS - 1; i >= 0; i--) begin
      if (!slot_valid[i]) empty_idx = SLOT_W'(i);
    end
  end

  assign victim_idx = (mode == MODE_NEXT_USE) ? max_key_idx : min_score_idx;
  assign fill_idx   = all_full ? victim_idx : empty_idx;

  always_comb begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      hit_vec[i]  = req_valid_i && any_hit && (hit_idx == SLOT_W'(i));
      fill_vec[i] = req_valid_i && !any_hit && (fill_idx == SLOT_W'(i));
      pred_vec[i] = pred_we_i && (pred_slot_i == SLOT_W'(i));
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_idx_q <= '0;
    end else if (req_valid_i && (cur_idx_q != '1)) begin
      cur_idx_q <= cur_idx_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      hit_o        <= 1'b0;
      fill_o       <= 1'b0;
      evict_o      <= 1'b0;
      slot_o       <= '0;
    end else begin
      resp_valid_o <= req_valid_i;
      hit_o        <= req_valid_i && any_hit;
      fill_o       <= req_valid_i && !any_hit;
      evict_o      <= req_valid_i && !any_hit && all_full;
      slot_o       <= req_valid_i ? (any_hit ? hit_idx : fill_idx) : slot_o;
    end
  end
endmodule

// File: rtl/reuse_circuit_set_chk.sv
module reuse_circuit_set_chk #(
  parameter int NUM_SLOTS = 8,
  parameter int SLOT_W    = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              resp_valid_o,
  input logic              hit_o,
  input logic              fill_o,
  input logic              evict_o,
  input logic [SLOT_W-1:0] slot_o
);
  logic [SLOT_W:0] free_fills_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) free_fills_q <= '0;
    else if (fill_o && !evict_o && (free_fills_q < (SLOT_W+1)'(NUM_SLOTS)))
      free_fills_q <= free_fills_q + (SLOT_W+1)'(1);
  end

  a_r1_resp_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> resp_valid_o);

  a_r1_no_spurious_resp: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !resp_valid_o);

  a_r12_hit_xor_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> (hit_o ^ fill_o));

  a_r12_evict_with_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_o |-> (fill_o && resp_valid_o));

  a_r12_evict_only_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evict_o |-> (free_fills_q >= (SLOT_W+1)'(NUM_SLOTS)));

  a_r2_empty_fill_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_o && !evict_o) |-> (free_fills_q < (SLOT_W+1)'(NUM_SLOTS)));

  a_r2_free_fills_in_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_o && !evict_o) |-> (slot_o == SLOT_W'(free_fills_q)));

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      a_r11_quiet_in_reset: assert (!resp_valid_o && !fill_o && !hit_o && !evict_o);
    end
  end
endmodule

bind reuse_circuit_set reuse_circuit_set_chk #(
  .NUM_SLOTS(NUM_SLOTS),
  .SLOT_W   (SLOT_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .resp_valid_o(resp_valid_o),
  .hit_o       (hit_o),
  .fill_o      (fill_o),
  .evict_o     (evict_o),
  .slot_o      (slot_o)
);

// File: tb/reuse_circuit_set_tb.sv
module reuse_circuit_set_tb;
  localparam int N       = 4;
  localparam int DEST_W  = 5;
  localparam int IDX_W   = 8;
  localparam int SCORE_W = 8;
  localparam int MAX_BIN = 4;
  localparam int SLOT_W  = 2;
  localparam int SPAN    = 1 << MAX_BIN;
  localparam int IMAX    = (1 << IDX_W) - 1;
  localparam int SMAX    = (1 << SCORE_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic [DEST_W-1:0] req_dest = '0;
  logic              mode = 1'b0;
  logic              pred_we = 1'b0;
  logic [SLOT_W-1:0] pred_slot = '0;
  logic [IDX_W-1:0]  pred_dist = '0;
  logic              pred_conf = 1'b0;
  logic              resp_valid, hit, fill, evict;
  logic [SLOT_W-1:0] slot;

  int checks = 0;
  int errors = 0;

  int m_valid[N];
  int m_tag[N];
  int m_score[N];
  int m_last[N];
  int m_pred[N];
  int m_conf[N];
  int m_cur;

  always #2 clk = ~clk;

  reuse_circuit_set #(
    .NUM_SLOTS(N), .DEST_W(DEST_W), .IDX_W(IDX_W),
    .SCORE_W(SCORE_W), .MAX_BIN(MAX_BIN), .SLOT_W(SLOT_W)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_dest_i(req_dest),
    .mode_i(mode), .pred_we_i(pred_we), .pred_slot_i(pred_slot),
    .pred_dist_i(pred_dist), .pred_conf_i(pred_conf),
    .resp_valid_o(resp_valid), .hit_o(hit), .fill_o(fill), .evict_o(evict), .slot_o(slot)
  );

  function automatic int next_use_key(int i);
    int s;
    s = m_last[i] + m_pred[i];
    if (m_conf[i] != 0 && s >= m_cur) return s - m_cur;
    return m_cur - m_last[i];
  endfunction

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_tag[i] = 0; m_score[i] = 0;
      m_last[i] = 0; m_pred[i] = 0; m_conf[i] = 0;
    end
    m_cur = 0;
  endtask

  task automatic model_step(input int dest, input bit md, input bit pw, input int ps,
                            input int pd, input bit pc,
                            output bit e_hit, output int e_slot, output bit e_evict);
    int hi, fs, gap, w, bk;
    hi = -1;
    for (int i = 0; i < N; i++) if (m_valid[i] != 0 && m_tag[i] == dest) hi = i;
    if (hi >= 0) begin
      gap = (m_cur > m_last[hi]) ? m_cur - m_last[hi] - 1 : 0;
      w = (gap >= SPAN) ? 0 : SPAN - gap;
      m_score[hi] = (m_score[hi] + w > SMAX) ? SMAX : m_score[hi] + w;
      m_last[hi] = m_cur;
      e_hit = 1'b1; e_slot = hi; e_evict = 1'b0;
    end else begin
      fs = -1;
      for (int i = 0; i < N; i++) if (m_valid[i] == 0 && fs < 0) fs = i;
      e_evict = (fs < 0);
      if (fs < 0) begin
        fs = 0;
        if (!md) begin
          for (int i = 1; i < N; i++) if (m_score[i] < m_score[fs]) fs = i;
        end else begin
          bk = next_use_key(0);
          for (int i = 1; i < N; i++) if (next_use_key(i) > bk) begin fs = i; bk = next_use_key(i); end
        end
      end
      m_valid[fs] = 1; m_tag[fs] = dest; m_score[fs] = 0;
      m_last[fs] = m_cur; m_pred[fs] = 0; m_conf[fs] = 0;
      e_hit = 1'b0; e_slot = fs;
    end
    if (pw && !(!e_hit && ps == e_slot)) begin
      m_pred[ps] = pd; m_conf[ps] = pc;
    end
    m_cur = (m_cur < IMAX) ? m_cur + 1 : IMAX;
  endtask

  // called right after a falling edge
  task automatic do_req(input int dest, input bit md, input bit pw, input int ps,
                        input int pd, input bit pc, input int hand_slot, input string tag);
    bit e_hit, e_evict;
    int e_slot;
    req_valid = 1'b1; req_dest = DEST_W'(dest); mode = md;
    pred_we = pw; pred_slot = SLOT_W'(ps); pred_dist = IDX_W'(pd); pred_conf = pc;
    model_step(dest, md, pw, ps, pd, pc, e_hit, e_slot, e_evict);
    @(negedge clk);
    req_valid = 1'b0; pred_we = 1'b0;
    checks++;
    if (!(resp_valid && hit == e_hit && fill == !e_hit && evict == e_evict && int'(slot) == e_slot)) begin
      errors++;
      $display("FAIL %s: got v=%0b h=%0b f=%0b e=%0b s=%0d exp v=1 h=%0b f=%0b e=%0b s=%0d",
               tag, resp_valid, hit, fill, evict, slot, e_hit, !e_hit, e_evict, e_slot);
    end
    if (hand_slot >= 0) begin
      checks++;
      if (int'(slot) != hand_slot) begin
        errors++;
        $display("FAIL %s: slot got %0d exp %0d", tag, slot, hand_slot);
      end
    end
  endtask

  task automatic pred_only(input int ps, input int pd, input bit pc);
    pred_we = 1'b1; pred_slot = SLOT_W'(ps); pred_dist = IDX_W'(pd); pred_conf = pc;
    m_pred[ps] = pd; m_conf[ps] = pc;
    @(negedge clk);
    pred_we = 1'b0;
    checks++;
    if (resp_valid) begin
      errors++;
      $display("FAIL R10: predictor write gave resp_valid=%0b exp 0", resp_valid);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    model_clear();
    checks++;
    if (resp_valid || hit || fill || evict) begin
      errors++;
      $display("FAIL R11: in reset v=%0b h=%0b f=%0b e=%0b exp all 0", resp_valid, hit, fill, evict);
    end
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (resp_valid) begin
      errors++;
      $display("FAIL R11: after reset resp_valid=%0b exp 0", resp_valid);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not end, got timeout exp completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd917));
    model_clear();
    @(negedge clk);
    do_reset();

    // R2 R3: empty slots fill in order; R1 hit
    do_req(10, 0, 0, 0, 0, 0, 0, "R2 fill0");
    do_req(11, 0, 0, 0, 0, 0, 1, "R2 fill1");
    do_req(12, 1, 0, 0, 0, 0, 2, "R2 fill2");
    do_req(13, 0, 0, 0, 0, 0, 3, "R2 fill3");
    do_req(12, 0, 0, 0, 0, 0, 2, "R1 hit");
    do_req(14, 0, 0, 0, 0, 0, -1, "R12 first evict");

    // R5 tie on zero scores goes to slot 0 (R3 new score 0)
    do_reset();
    for (int d = 1; d <= 4; d++) do_req(d, 0, 0, 0, 0, 0, d - 1, "R2 fill");
    do_req(5, 0, 0, 0, 0, 0, 0, "R5 R3 tie lowest");

    // R4 weights: 13,29,12,12 -> slot 2
    do_reset();
    for (int d = 1; d <= 4; d++) do_req(d, 0, 0, 0, 0, 0, d - 1, "R2 fill");
    do_req(1, 0, 0, 0, 0, 0, 0, "R4 hit");
    do_req(2, 0, 0, 0, 0, 0, 1, "R4 hit");
    do_req(2, 0, 0, 0, 0, 0, 1, "R4 hit");
    do_req(3, 0, 0, 0, 0, 0, 2, "R4 hit");
    do_req(4, 0, 0, 0, 0, 0, 3, "R4 hit");
    do_req(9, 0, 0, 0, 0, 0, 2, "R4 R5 lowest score");

    // R4 distant reuse weighs zero
    do_reset();
    for (int d = 1; d <= 4; d++) do_req(d, 0, 0, 0, 0, 0, d - 1, "R2 fill");
    do_req(1, 0, 0, 0, 0, 0, 0, "R4 hit");
    for (int k = 0; k < 16; k++) do_req(2, 0, 0, 0, 0, 0, 1, "R4 hit");
    do_req(3, 0, 0, 0, 0, 0, 2, "R4 far hit");
    do_req(4, 0, 0, 0, 0, 0, 3, "R4 far hit");
    do_req(9, 0, 0, 0, 0, 0, 2, "R4 zero weight far reuse");

    // R9 score saturation: 255,240,240,240 -> slot 1
    do_reset();
    do_req(1, 0, 0, 0, 0, 0, 0, "R2 fill");
    for (int k = 0; k < 20; k++) do_req(1, 0, 0, 0, 0, 0, 0, "R9 hit");
    for (int d = 2; d <= 4; d++) begin
      do_req(d, 0, 0, 0, 0, 0, d - 1, "R2 fill");
      for (int k = 0; k < 15; k++) do_req(d, 0, 0, 0, 0, 0, d - 1, "R9 hit");
    end
    do_req(9, 0, 0, 0, 0, 0, 1, "R9 score saturates");
    // R9 index saturation
    for (int k = 0; k < 200; k++) do_req(1, 0, 0, 0, 0, 0, 0, "R9 index run");
    do_req(20, 1, 0, 0, 0, 0, -1, "R9 saturated index evict");
    do_req(21, 1, 0, 0, 0, 0, -1, "R9 saturated index evict");

    // R6 R7 R8 next-use keys 16,3,2,9 -> slot 0; then slot 3
    do_reset();
    for (int d = 1; d <= 4; d++) do_req(d, 1, 0, 0, 0, 0, d - 1, "R2 fill");
    pred_only(0, 20, 1);
    pred_only(1, 2, 1);
    pred_only(2, 30, 0);
    pred_only(3, 10, 1);
    do_req(7, 1, 0, 0, 0, 0, 0, "R6 R8 farthest eta");
    do_req(8, 1, 0, 0, 0, 0, 3, "R7 R8 low confidence decays");

    // R10 collisions
    do_reset();
    for (int d = 1; d <= 3; d++) do_req(d, 1, 0, 0, 0, 0, d - 1, "R2 fill");
    do_req(4, 1, 1, 3, 100, 1, 3, "R10 fill with pred write");
    do_req(5, 1, 0, 0, 0, 0, 0, "R10 pred discarded on fill");
    do_req(2, 1, 1, 1, 50, 1, 1, "R10 hit with pred write");
    do_req(9, 1, 0, 0, 0, 0, 1, "R10 pred kept on hit");

    // random mix
    for (int c = 0; c < 14; c++) begin
      do_reset();
      for (int k = 0; k < 200; k++) begin
        bit pw;
        pw = ($urandom % 10) < 3;
        if (($urandom % 8) == 0) begin
          pred_only(int'($urandom % N), int'($urandom % 40), 1'($urandom));
        end
        do_req(int'($urandom % 7), 1'($urandom), pw, int'($urandom % N),
               int'($urandom % 40), 1'($urandom), -1, "R1 R4 R5 R6 R7 R8 R10 random");
      end
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule